// File: doc/BRIEF.md
# Per-Pin Interrupt Sense and Status

This block converts already-filtered pin levels into sticky interrupt status and wake status bits, one set per pin. Each pin has its own configuration: an interrupt enable, a separate delivery (unmask) control, a level/edge trigger select, and a 2-bit sense field that picks low/falling, high/rising, or both-edge detection. A detection is latched into the interrupt status while the enable is set. The same detection is latched into the wake status while wake is enabled.

Software clears either status by writing a one on the matching clear strobe. The masked request, which is the interrupt status gated by the unmask control, goes to a downstream aggregator. A pending output per pin reports that either status bit is set.

The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block.

Top module: `pin_irq_sense`

## Requirements
- R1: While reset is asserted, and after it is released, every int_sts, wake_sts, pending and irq_req bit reads 0 until a detection occurs.
- R2: The sense field per pin is coded 0 = active low / falling edge, 1 = active high / rising edge, 2 = both edges (edge mode only; in level mode it never sets status), 3 = reserved and never sets any status.
- R3: A lvl_mode bit of 1 selects level sensing, where status sets on every clock the active level is present. A lvl_mode bit of 0 selects edge sensing, where status sets only on a change of the pin between two consecutive clock samples.
- R4: Interrupt status sets only on a clock where irq_en is 1. A detection while irq_en is 0 is dropped. Status already set holds when irq_en falls.
- R5: irq_req is 1 exactly when int_sts is 1 and irq_unmask is 1 (unmask 1 means delivered). The unmask control does not affect int_sts.
- R6: A 1 on clr_int clears int_sts on the next clock edge unless R8 applies. A 0 on clr_int has no effect, and status holds with no detection and no clear.
- R7: In level mode a clear wins over a detection in the same cycle, so status drops. If the active level is still present, status sets again one clock later.
- R8: In edge mode a detected edge in the same cycle as a clear wins, so status stays 1.
- R9: wake_sts latches the same detection gated by wake_en instead of irq_en, clears with its own clr_wake strobe, and never drives irq_req.
- R10: pending is 1 whenever int_sts or wake_sts is 1.
- R11: The first pin sample after reset release is not treated as an edge. A pin held high through reset produces no rising-edge status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | PINS | Filtered pin levels |
| irq_en | input | PINS | Interrupt latch enable per pin |
| irq_unmask | input | PINS | 1 delivers status to irq_req |
| wake_en | input | PINS | Wake latch enable per pin |
| lvl_mode | input | PINS | 1 level sensing, 0 edge sensing |
| sense_sel | input | 2*PINS | Sense code, pin i at bits [2i+1:2i] |
| clr_int | input | PINS | Write-one-to-clear strobe for int_sts |
| clr_wake | input | PINS | Write-one-to-clear strobe for wake_sts |
| int_sts | output | PINS | Latched interrupt status |
| wake_sts | output | PINS | Latched wake status |
| pending | output | PINS | Either status set |
| irq_req | output | PINS | Masked interrupt request |

## Verification
The bench targets the two opposite clear-versus-detect priorities. In level mode, a design that let the detection win would never show status dropping under a clear. In edge mode, a design that let the clear win would lose an edge arriving with the clear.

It also drives the reserved sense code and the both-edge code in level mode, where a loose decoder would latch status. It toggles the pin with the enable low, where a design gating the wrong term would latch a dropped event.

A pin held high through reset checks that edge history is armed only after the first sample; a design without that would report a spurious rising edge. A wake-only detection checks that wake status raises pending without ever reaching the request output.

// File: rtl/pis_pkg.sv
package pis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_BOTH = 2'd2,
    SENSE_RSVD = 2'd3
  } sense_sel_e;

  localparam int unsigned SENSE_W = 2;
endpackage

// File: rtl/pis_rst_sync.sv
module pis_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/pis_detect.sv
module pis_detect
  import pis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  logic               lvl_mode,
  input  logic [SENSE_W-1:0] sel,
  output logic               hit
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;
  logic rise, fall;
  sense_sel_e mode;

  assign mode = sense_sel_e'(sel);

  always_comb begin
    prev_d  = pin;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  assign rise = armed_q &  pin & ~prev_q;
  assign fall = armed_q & ~pin &  prev_q;

  always_comb begin
    hit = 1'b0;
    if (lvl_mode) begin
      case (mode)
        SENSE_LOW:  hit = ~pin;
        SENSE_HIGH: hit = pin;
        default:    hit = 1'b0;
      endcase
    end else begin
      case (mode)
        SENSE_LOW:  hit = fall;
        SENSE_HIGH: hit = rise;
        SENSE_BOTH: hit = rise | fall;
        default:    hit = 1'b0;
      endcase
    end
  end

  // R3
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && armed_q && (pin == prev_q)) |-> !hit);
endmodule

// File: rtl/pis_status_cell.sv
module pis_status_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic gate,
  input  logic clr,
  input  logic clr_wins,
  output logic sts
);
  logic sts_q, sts_d;
  logic set_now;

  assign set_now = hit & gate;

  always_comb begin
    sts_d = sts_q;
    if (clr_wins) begin
      if (clr)          sts_d = 1'b0;
      else if (set_now) sts_d = 1'b1;
    end else begin
      if (set_now)      sts_d = 1'b1;
      else if (clr)     sts_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;

  // R4
  rise_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(gate && hit));
  // R7
  lvl_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && clr_wins) |=> !sts_q);
  // R8
  edge_hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wins && hit && gate) |=> sts_q);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(hit && gate)) |=> $stable(sts_q));
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pis_pkg::*;
#(
  parameter int unsigned PINS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PINS-1:0]         pin_level,
  input  logic [PINS-1:0]         irq_en,
  input  logic [PINS-1:0]         irq_unmask,
  input  logic [PINS-1:0]         wake_en,
  input  logic [PINS-1:0]         lvl_mode,
  input  logic [SENSE_W*PINS-1:0] sense_sel,
  input  logic [PINS-1:0]         clr_int,
  input  logic [PINS-1:0]         clr_wake,
  output logic [PINS-1:0]         int_sts,
  output logic [PINS-1:0]         wake_sts,
  output logic [PINS-1:0]         pending,
  output logic [PINS-1:0]         irq_req
);
  logic rst_n_sync;

  pis_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic hit;

    pis_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .pin      (pin_level[i]),
      .lvl_mode (lvl_mode[i]),
      .sel      (sense_sel[SENSE_W*i +: SENSE_W]),
      .hit      (hit)
    );

    pis_status_cell u_int (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .hit      (hit),
      .gate     (irq_en[i]),
      .clr      (clr_int[i]),
      .clr_wins (lvl_mode[i]),
      .sts      (int_sts[i])
    );

    pis_status_cell u_wake (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .hit      (hit),
      .gate     (wake_en[i]),
      .clr      (clr_wake[i]),
      .clr_wins (lvl_mode[i]),
      .sts      (wake_sts[i])
    );

    assign irq_req[i] = int_sts[i] & irq_unmask[i];
    assign pending[i] = int_sts[i] | wake_sts[i];

    // R9
    wake_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (!int_sts[i]) |-> !irq_req[i]);
  end
endmodule

// File: tb/pin_irq_sense_bench.sv
module pin_irq_sense_bench;
  localparam int PINS = 4;
  localparam int NV = 35;

  logic clk = 1'b0;
  logic rst_n;
  logic [PINS-1:0] pin_level, irq_en, irq_unmask, wake_en, lvl_mode, clr_int, clr_wake;
  logic [2*PINS-1:0] sense_sel;
  logic [PINS-1:0] int_sts, wake_sts, pending, irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_irq_sense #(.PINS(PINS)) u_pin_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .irq_en(irq_en),
    .irq_unmask(irq_unmask), .wake_en(wake_en), .lvl_mode(lvl_mode),
    .sense_sel(sense_sel), .clr_int(clr_int), .clr_wake(clr_wake),
    .int_sts(int_sts), .wake_sts(wake_sts), .pending(pending), .irq_req(irq_req)
  );

  // fields: pin en unmask lvl sel[1:0] clr exp_sts exp_req
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b0_1_1_0_01_0_0_0, // R1 idle
    9'b1_1_1_0_01_0_1_1, // R2 rising sets
    9'b1_1_1_0_01_0_1_1, // R6 holds
    9'b1_1_1_0_01_1_0_0, // R6 clear
    9'b0_1_1_0_01_0_0_0, // R2 falling ignored
    9'b1_1_0_0_01_0_1_0, // R5 masked
    9'b1_1_1_0_01_0_1_1, // R5 unmasked
    9'b0_1_1_0_01_1_0_0, // R6 clear
    9'b1_1_1_0_01_1_1_1, // R8 edge beats clear
    9'b1_1_1_0_01_1_0_0, // R6 clear
    9'b1_1_1_0_00_0_0_0, // R3 no change
    9'b0_1_1_0_00_0_1_1, // R2 falling sets
    9'b0_1_1_0_00_1_0_0,
    9'b1_1_1_0_10_0_1_1, // R2 both rise
    9'b1_1_1_0_10_1_0_0,
    9'b0_1_1_0_10_0_1_1, // R2 both fall
    9'b0_1_1_0_10_1_0_0,
    9'b1_1_1_0_11_0_0_0, // R2 reserved
    9'b0_1_1_0_11_0_0_0, // R2 reserved
    9'b1_0_1_0_01_0_0_0, // R4 disabled
    9'b0_0_1_0_01_0_0_0,
    9'b0_1_1_1_01_0_0_0, // R3 level high idle
    9'b1_1_1_1_01_0_1_1, // R3 level high sets
    9'b1_1_1_1_01_1_0_0, // R7 clear wins
    9'b1_1_1_1_01_0_1_1, // R7 reasserts
    9'b0_1_1_1_01_1_0_0,
    9'b0_1_1_1_01_0_0_0,
    9'b0_1_1_1_00_0_1_1, // R3 level low
    9'b1_1_1_1_00_1_0_0,
    9'b0_1_1_1_10_0_0_0, // R2 both in level mode
    9'b1_1_1_1_10_0_0_0, // R2 both in level mode
    9'b1_0_1_1_01_0_0_0, // R4 disabled level
    9'b1_1_1_1_01_0_1_1,
    9'b0_0_1_1_01_0_1_1, // R4 holds when disabled
    9'b0_0_1_1_01_1_0_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_level = 4'b0010;
    irq_en = 4'b0010;
    irq_unmask = 4'b0010;
    wake_en = '0;
    lvl_mode = '0;
    sense_sel = 8'b00_00_01_00;
    clr_int = '0;
    clr_wake = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 int_sts in reset", int_sts, 0);
    check("R1 irq_req in reset", irq_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) tick();
    check("R1 status after reset", {int_sts, wake_sts, pending}, 0);
    check("R11 no edge from first sample", int_sts[1], 0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      pin_level[0] = VEC[k][8];
      irq_en[0] = VEC[k][7];
      irq_unmask[0] = VEC[k][6];
      lvl_mode[0] = VEC[k][5];
      sense_sel[1:0] = VEC[k][4:3];
      clr_int[0] = VEC[k][2];
      tick();
      check($sformatf("R2-R8 vec %0d int_sts", k), int_sts[0], VEC[k][1]);
      check($sformatf("R5 vec %0d irq_req", k), irq_req[0], VEC[k][0]);
      check($sformatf("R10 vec %0d pending", k), pending[0], VEC[k][1]);
      check($sformatf("R9 vec %0d wake and others", k), {wake_sts, int_sts[3:1]}, 0);
    end
    @(negedge clk);
    clr_int = '0;

    // R9 wake-only detection on pin 2
    sense_sel[5:4] = 2'd1;
    wake_en[2] = 1'b1;
    tick();
    @(negedge clk);
    pin_level[2] = 1'b1;
    tick();
    check("R9 wake sets", wake_sts[2], 1);
    check("R9 int stays clear", int_sts[2], 0);
    check("R9 no request", irq_req[2], 0);
    check("R10 pending from wake", pending[2], 1);
    @(negedge clk);
    clr_int[2] = 1'b1;
    tick();
    check("R9 clr_int leaves wake", wake_sts[2], 1);
    @(negedge clk);
    clr_int[2] = 1'b0;
    clr_wake[2] = 1'b1;
    tick();
    check("R9 clr_wake clears", wake_sts[2], 0);
    check("R10 pending drops", pending[2], 0);
    @(negedge clk);
    clr_wake[2] = 1'b0;
    tick();
    check("R11 pin held high never latched", int_sts[1], 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule